// File: doc/BRIEF.md
# Access Permission Check Unit

This block decides whether a memory access that has already been translated must be aborted, using only the access permission code stored in the translation entry. Each check request supplies the 3-bit permission code, whether the access is privileged, and whether it is a write. Two control inputs come from the system control register: an extended page table enable bit and a 2-bit legacy protection field.

When extended page tables are enabled, all three permission bits are decoded. The upper bit selects the read-only encodings, and one of them is reserved. When extended page tables are disabled, the upper permission bit is ignored. In that case a zero permission code does not always abort: the legacy protection field decides the outcome. Domain checks, execute-never handling and the table walk are done elsewhere.

The verdict is registered. It appears one cycle after the check strobe, together with a fault class and a copy of the write flag, which are used for fault reporting.

Top module: `ap_check_unit`

## Requirements
- R1: With the extended page table enable high and the permission code 3'b000, every access aborts.
- R2: With the extended page table enable low, permission bits [1:0] equal to 2'b00 and the legacy field equal to 2, only writes abort.
- R3: With the extended page table enable low, permission bits [1:0] equal to 2'b00 and the legacy field equal to 1, writes abort and unprivileged reads abort.
- R4: With the extended page table enable low, permission bits [1:0] equal to 2'b00 and the legacy field equal to 0 or 3, every access aborts.
- R5: With permission bits [1:0] equal to 2'b01, only unprivileged accesses abort. This holds when the enable is low, or when permission bit 2 is 0.
- R6: With permission bits [1:0] equal to 2'b10, only unprivileged writes abort. With permission bits [1:0] equal to 2'b11, no access aborts. Both hold when the enable is low, or when permission bit 2 is 0.
- R7: With the enable low, permission bit 2 has no effect on the outcome. With the enable high, the legacy field has no effect on the outcome.
- R8: With the enable high and permission bit 2 equal to 1, the codes behave as follows. Code 3'b101 aborts writes and unprivileged accesses. Codes 3'b110 and 3'b111 abort writes only. Code 3'b100 is reserved and always aborts, with the fault class reserved.
- R9: The result is valid in the cycle after `checkValid`, and `respValid` is high only in that cycle. `faultWrite` carries the write flag of that request. `faultKind` is 0 for no abort, 1 for a permission abort and 2 for the reserved code. The results hold their values while no new check arrives.
- R10: After reset, `respValid`, `abortOut`, `faultKind` and `faultWrite` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| checkValid | input | 1 | Check strobe; the other inputs are sampled when it is high |
| apField | input | 3 | Access permission code from the translation entry |
| isPriv | input | 1 | The access is privileged |
| isWrite | input | 1 | The access is a write |
| xpEnable | input | 1 | Extended page table enable (system control bit 23) |
| legacyProt | input | 2 | Legacy protection field (system control bits [9:8]) |
| respValid | output | 1 | Result valid, one cycle after the strobe |
| abortOut | output | 1 | The access must abort |
| faultKind | output | 2 | 0 none, 1 permission, 2 reserved encoding |
| faultWrite | output | 1 | Registered copy of the request's write flag |

## Verification
The bench sweeps every combination of the 3-bit permission code, the enable bit, the 4 legacy field values, privilege and direction.

- Comparing the privileged and unprivileged results separates the privilege-only codes from the write-only codes.
- Varying the legacy field while the enable is high shows that the field is ignored in that mode.
- Varying permission bit 2 while the enable is low shows that the bit is ignored in that mode.
- An idle cycle after each check shows that the valid pulse is one cycle wide and that the result holds.

// File: rtl/ap_check_pkg.sv
package ap_check_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE = 2'd0,
    FAULT_PERM = 2'd1,
    FAULT_RSVD = 2'd2
  } faultKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clearValid;
  } apStrobe_t;

  // rights granted by one permission encoding
  typedef struct packed {
    logic privRd;
    logic privWr;
    logic userRd;
    logic userWr;
    logic rsvd;
  } apRights_t;

endpackage

// File: rtl/ap_check_ctrl.sv
module ap_check_ctrl
  import ap_check_pkg::*;
(
  input  logic      checkValid,
  output apStrobe_t stb
);
  always_comb begin
    stb.capture    = checkValid;
    stb.clearValid = ~checkValid;
  end
endmodule

// File: rtl/ap_check_dp.sv
module ap_check_dp
  import ap_check_pkg::*;
#(
  parameter int AP_W   = 3,
  parameter int PROT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  apStrobe_t         stb,
  input  logic [AP_W-1:0]   apField,
  input  logic              isPriv,
  input  logic              isWrite,
  input  logic              xpEnable,
  input  logic [PROT_W-1:0] legacyProt,
  output logic              respValid,
  output logic              abortOut,
  output faultKind_e        faultKind,
  output logic              faultWrite
);
  localparam int LOW_W = AP_W - 1;

  apRights_t  rights;
  logic       allowed;
  logic       abortD;
  faultKind_e kindD;
  logic [LOW_W-1:0] apLow;
  logic       apHigh;

  assign apLow  = apField[LOW_W-1:0];
  assign apHigh = apField[AP_W-1] & xpEnable;

  // rights table per encoding
  always_comb begin
    rights = '0;
    if (apHigh) begin
      unique case (apLow)
        2'b00: rights = '{privRd: 1'b0, privWr: 1'b0, userRd: 1'b0, userWr: 1'b0, rsvd: 1'b1};
        2'b01: rights = '{privRd: 1'b1, privWr: 1'b0, userRd: 1'b0, userWr: 1'b0, rsvd: 1'b0};
        default: rights = '{privRd: 1'b1, privWr: 1'b0, userRd: 1'b1, userWr: 1'b0, rsvd: 1'b0};
      endcase
    end else begin
      unique case (apLow)
        2'b00: begin
          if (xpEnable) rights = '0;
          else begin
            unique case (legacyProt)
              2'd2:    rights = '{privRd: 1'b1, privWr: 1'b0, userRd: 1'b1, userWr: 1'b0, rsvd: 1'b0};
              2'd1:    rights = '{privRd: 1'b1, privWr: 1'b0, userRd: 1'b0, userWr: 1'b0, rsvd: 1'b0};
              default: rights = '0;
            endcase
          end
        end
        2'b01: rights = '{privRd: 1'b1, privWr: 1'b1, userRd: 1'b0, userWr: 1'b0, rsvd: 1'b0};
        2'b10: rights = '{privRd: 1'b1, privWr: 1'b1, userRd: 1'b1, userWr: 1'b0, rsvd: 1'b0};
        default: rights = '{privRd: 1'b1, privWr: 1'b1, userRd: 1'b1, userWr: 1'b1, rsvd: 1'b0};
      endcase
    end
  end

  always_comb begin
    if (isPriv) allowed = isWrite ? rights.privWr : rights.privRd;
    else        allowed = isWrite ? rights.userWr : rights.userRd;
    abortD = ~allowed | rights.rsvd;
    if (rights.rsvd)  kindD = FAULT_RSVD;
    else if (abortD)  kindD = FAULT_PERM;
    else              kindD = FAULT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid  <= 1'b0;
      abortOut   <= 1'b0;
      faultKind  <= FAULT_NONE;
      faultWrite <= 1'b0;
    end else begin
      if (stb.capture) begin
        respValid  <= 1'b1;
        abortOut   <= abortD;
        faultKind  <= kindD;
        faultWrite <= isWrite;
      end else if (stb.clearValid) begin
        respValid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ap_check_unit.sv
module ap_check_unit
  import ap_check_pkg::*;
#(
  parameter int AP_W   = 3,
  parameter int PROT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              checkValid,
  input  logic [AP_W-1:0]   apField,
  input  logic              isPriv,
  input  logic              isWrite,
  input  logic              xpEnable,
  input  logic [PROT_W-1:0] legacyProt,
  output logic              respValid,
  output logic              abortOut,
  output logic [1:0]        faultKind,
  output logic              faultWrite
);
  apStrobe_t  stb;
  faultKind_e kindQ;

  ap_check_ctrl u_ctrl (
    .checkValid (checkValid),
    .stb        (stb)
  );

  ap_check_dp #(.AP_W(AP_W), .PROT_W(PROT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .apField    (apField),
    .isPriv     (isPriv),
    .isWrite    (isWrite),
    .xpEnable   (xpEnable),
    .legacyProt (legacyProt),
    .respValid  (respValid),
    .abortOut   (abortOut),
    .faultKind  (kindQ),
    .faultWrite (faultWrite)
  );

  assign faultKind = kindQ;
endmodule

// File: rtl/ap_check_sva.sv
module ap_check_sva #(
  parameter int AP_W   = 3,
  parameter int PROT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              checkValid,
  input logic [AP_W-1:0]   apField,
  input logic              isPriv,
  input logic              isWrite,
  input logic              xpEnable,
  input logic [PROT_W-1:0] legacyProt,
  input logic              respValid,
  input logic              abortOut,
  input logic [1:0]        faultKind,
  input logic              faultWrite
);
  p_all_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid && xpEnable && apField == 3'b000 |=> abortOut && faultKind == 2'd1);

  p_legacy_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid && !xpEnable && apField[1:0] == 2'b00 && legacyProt == 2'd2
      |=> abortOut == $past(isWrite));

  p_legacy_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid && !xpEnable && apField[1:0] == 2'b00 && (legacyProt == 2'd0 || legacyProt == 2'd3)
      |=> abortOut);

  p_user_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid && apField[1:0] == 2'b01 && !(xpEnable && apField[2])
      |=> abortOut == !$past(isPriv));

  p_full_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid && apField[1:0] == 2'b11 && !(xpEnable && apField[2]) |=> !abortOut);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid && xpEnable && apField == 3'b100 |=> abortOut && faultKind == 2'd2);

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    checkValid |=> respValid && faultWrite == $past(isWrite));

  p_resp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !checkValid |=> !respValid && $stable(abortOut) && $stable(faultKind));

  p_kind_consistent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (abortOut == (faultKind != 2'd0)) && faultKind != 2'd3);
endmodule

bind ap_check_unit ap_check_sva #(.AP_W(AP_W), .PROT_W(PROT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .checkValid (checkValid),
  .apField    (apField),
  .isPriv     (isPriv),
  .isWrite    (isWrite),
  .xpEnable   (xpEnable),
  .legacyProt (legacyProt),
  .respValid  (respValid),
  .abortOut   (abortOut),
  .faultKind  (faultKind),
  .faultWrite (faultWrite)
);

// File: tb/ap_check_unit_test.sv
`timescale 1ns/1ps
module ap_check_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       checkValid = 1'b0;
  logic [2:0] apField = 3'b0;
  logic       isPriv = 1'b0;
  logic       isWrite = 1'b0;
  logic       xpEnable = 1'b0;
  logic [1:0] legacyProt = 2'b0;
  logic       respValid, abortOut, faultWrite;
  logic [1:0] faultKind;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ap_check_unit uut (
    .clk(clk), .rst_n(rst_n), .checkValid(checkValid), .apField(apField),
    .isPriv(isPriv), .isWrite(isWrite), .xpEnable(xpEnable), .legacyProt(legacyProt),
    .respValid(respValid), .abortOut(abortOut), .faultKind(faultKind), .faultWrite(faultWrite)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected verdict from the written rules
  function automatic bit expAbort(bit xp, bit [1:0] rs, bit [2:0] ap, bit pv, bit wr);
    bit [2:0] code;
    code = xp ? ap : {1'b0, ap[1:0]};
    case (code)
      3'd0: begin
        if (xp) return 1'b1;
        if (rs == 2'd2) return wr;
        if (rs == 2'd1) return wr | ~pv;
        return 1'b1;
      end
      3'd1: return ~pv;
      3'd2: return ~pv & wr;
      3'd3: return 1'b0;
      3'd4: return 1'b1;
      3'd5: return wr | ~pv;
      default: return wr;
    endcase
  endfunction

  function automatic string reqOf(bit xp, bit [1:0] rs, bit [2:0] ap);
    if (xp && ap[2]) return "R8";
    if (!xp && ap[2]) return "R7";
    if (ap[1:0] == 2'b00) begin
      if (xp) return "R1";
      if (rs == 2'd2) return "R2";
      if (rs == 2'd1) return "R3";
      return "R4";
    end
    if (ap[1:0] == 2'b01) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "respValid", respValid, 0);
    check("R10", "abortOut", abortOut, 0);
    check("R10", "faultKind", faultKind, 0);
    check("R10", "faultWrite", faultWrite, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int xp = 0; xp < 2; xp++) begin
      for (int rs = 0; rs < 4; rs++) begin
        for (int ap = 0; ap < 8; ap++) begin
          for (int pw = 0; pw < 4; pw++) begin
            bit expA;
            int expK;
            string rq;
            xpEnable   = xp[0];
            legacyProt = rs[1:0];
            apField    = ap[2:0];
            isPriv     = pw[1];
            isWrite    = pw[0];
            checkValid = 1'b1;
            expA = expAbort(xp[0], rs[1:0], ap[2:0], pw[1], pw[0]);
            expK = (xp == 1 && ap == 4) ? 2 : (expA ? 1 : 0);
            rq = reqOf(xp[0], rs[1:0], ap[2:0]);
            @(negedge clk);
            checkValid = 1'b0;
            // change inputs to show they are not sampled without strobe
            isWrite = ~isWrite;
            apField = ~apField;
            check(rq, "abortOut", abortOut, expA);
            check(rq, "faultKind", faultKind, expK);
            check("R9", "faultWrite", faultWrite, pw[0]);
            check("R9", "respValid", respValid, 1);
            @(negedge clk);
            check("R9", "respValid idle", respValid, 0);
            check("R9", "abortOut hold", abortOut, expA);
            check("R9", "faultWrite hold", faultWrite, pw[0]);
            // R7: the ignored input must not change the outcome
            if (!xp[0] && ap[2]) begin
              bit lowA;
              lowA = expAbort(1'b0, rs[1:0], {1'b0, ap[1:0]}, pw[1], pw[0]);
              check("R7", "upper bit ignored", abortOut, lowA);
            end
            if (xp[0]) begin
              bit rs0A;
              rs0A = expAbort(1'b1, 2'd2, ap[2:0], pw[1], pw[0]);
              check("R7", "legacy field ignored", abortOut, rs0A);
            end
          end
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule